// File: doc/BRIEF.md
# Per-CPU Highest-Pending Interrupt Selector

This block finds, for each CPU port of an interrupt distributor, the interrupt source that CPU should take next. Each CPU has its own enable and pending vector over a shared set of sources. Every source has one 8-bit priority, and a numerically lower value means a more urgent source. For each CPU, a comparison tree over the sources that are both enabled and pending picks the most urgent one. The result is registered, so the outputs reflect the inputs one clock after they change.

Two per-CPU thresholds act on the winning priority. The priority mask decides whether the winner is reported at all: its ID appears on the highest-pending output only when its priority is below the mask. The running priority is the priority of the interrupt the CPU is servicing now, or 0x100 when it is idle. The request line is raised only when the winner is also more urgent than that running priority. A global distributor enable and a per-CPU interface enable force the CPU's outputs to the idle state.

Top module: `hpend_select`

## Requirements
- R1: A source counts as a candidate for a CPU only when both its enable bit and its pending bit for that CPU are set. Enabled sources that are not pending, and pending sources that are not enabled, are never reported.
- R2: Among the candidates, the one with the numerically smallest priority is chosen.
- R3: When several candidates share the smallest priority, the one with the lowest source ID is chosen.
- R4: With no candidate, the reported ID is 1023 (spurious) and the request line is low.
- R5: The chosen ID is reported only if its priority is strictly below the CPU's 8-bit priority mask. Otherwise the reported ID is 1023 and the request is low.
- R6: The request line is high only when an ID is reported and its priority is also strictly below the CPU's 9-bit running priority, where 0x100 means idle.
- R7: While the global enable is low, every CPU reports 1023 and holds its request low.
- R8: While a CPU's interface enable is low, that CPU reports 1023 and holds its request low. The other CPUs are unaffected.
- R9: Outputs reflect the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.
- R10: Under synchronous active-high reset, all IDs read 1023 and all requests are low.
- R11: Each CPU's result depends only on its own enable, pending, mask, running-priority and interface-enable inputs, plus the shared priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_en_i | input | 1 | Global distributor enable |
| cpu_en_i | input | NUM_CPU | Per-CPU interface enable |
| src_en_i | input | NUM_CPU*NUM_SRC | Enable bits; bit c*NUM_SRC+s belongs to CPU c, source s |
| src_pend_i | input | NUM_CPU*NUM_SRC | Pending bits, same layout as src_en_i |
| src_prio_i | input | NUM_SRC*8 | Priority of source s in bits s*8+:8 |
| prio_mask_i | input | NUM_CPU*8 | Priority mask of CPU c in bits c*8+:8 |
| run_prio_i | input | NUM_CPU*9 | Running priority of CPU c in bits c*9+:9, 0x100 = idle |
| hp_id_o | output | NUM_CPU*10 | Highest-pending ID of CPU c in bits c*10+:10, 1023 = none |
| irq_o | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The assertions assume that every input has a defined value and is stable around each rising edge. They also assume that the running priority never exceeds 0x100. The bench changes inputs only on falling edges and draws running priorities from 0 up to 0x100. Directed steps cover the threshold edges: the mask and the running priority set equal to the winning priority, and set one above it. A random phase packs priorities into a few values so that ties occur often. The random phase also includes sources that sit next to the padded leaves of the comparison tree.

// File: rtl/hpsel_pkg.sv
package hpsel_pkg;

    localparam int ID_W    = 10;
    localparam int PRIO_W  = 8;
    localparam int RPRIO_W = 9;

    localparam logic [ID_W-1:0]    SPURIOUS_ID = 10'd1023;
    localparam logic [RPRIO_W-1:0] NO_PRIO     = 9'h100;

    typedef struct packed {
        logic [RPRIO_W-1:0] prio;
        logic [ID_W-1:0]    id;
    } cand_t;

    function automatic cand_t empty_cand();
        cand_t c;
        c.prio = NO_PRIO;
        c.id   = SPURIOUS_ID;
        return c;
    endfunction

    // lo holds the lower source IDs; hi replaces it only on a strictly smaller priority
    function automatic cand_t pick_better(cand_t lo, cand_t hi);
        return (hi.prio < lo.prio) ? hi : lo;
    endfunction

endpackage

// File: rtl/hpsel_merge.sv
module hpsel_merge
    import hpsel_pkg::*;
(
    input  cand_t lo,
    input  cand_t hi,
    output cand_t win
);
    assign win = pick_better(lo, hi);
endmodule

// File: rtl/hpsel_tree.sv
module hpsel_tree
    import hpsel_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [NUM_SRC-1:0]        src_pend,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    output cand_t                     best
);
    localparam int LVL    = $clog2(NUM_SRC);
    localparam int LEAVES = 1 << LVL;

    // heap layout: node i has children 2i (lower IDs) and 2i+1
    cand_t node [1:2*LEAVES-1];

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < NUM_SRC) begin : g_real
            assign node[LEAVES+k] = (src_en[k] && src_pend[k])
                ? cand_t'{prio: {1'b0, src_prio[k*PRIO_W +: PRIO_W]}, id: ID_W'(k)}
                : empty_cand();
        end else begin : g_pad
            assign node[LEAVES+k] = empty_cand();
        end
    end

    for (genvar i = 1; i < LEAVES; i++) begin : g_node
        hpsel_merge u_merge (
            .lo  (node[2*i]),
            .hi  (node[2*i+1]),
            .win (node[i])
        );
    end

    assign best = node[1];

    logic winner_live;
    always_comb begin
        winner_live = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (ID_W'(k) == best.id) winner_live = src_en[k] && src_pend[k];
        end
    end

    always_comb begin
        if (!$isunknown(best)) begin
            assert_empty_pair_R4: assert ((best.prio == NO_PRIO) == (best.id == SPURIOUS_ID))
                else $error("tree winner priority and ID disagree on emptiness");
            assert_live_winner_R1: assert (best.id == SPURIOUS_ID || winner_live)
                else $error("tree winner is not enabled and pending");
        end
    end

endmodule

// File: rtl/hpsel_gate.sv
module hpsel_gate
    import hpsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cand_t              best,
    input  logic               dist_en,
    input  logic               cpu_en,
    input  logic [PRIO_W-1:0]  mask,
    input  logic [RPRIO_W-1:0] run_prio,
    output logic [ID_W-1:0]    id_q,
    output logic               irq_q
);
    logic open_gate;
    logic under_mask;

    assign open_gate  = dist_en && cpu_en;
    assign under_mask = best.prio < {1'b0, mask};

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= SPURIOUS_ID;
            irq_q <= 1'b0;
        end else if (!open_gate || !under_mask) begin
            id_q  <= SPURIOUS_ID;
            irq_q <= 1'b0;
        end else begin
            id_q  <= best.id;
            irq_q <= best.prio < run_prio;
        end
    end

    assert_global_off_R7: assert property (@(posedge clk) disable iff (rst)
        !dist_en |=> (!irq_q && id_q == SPURIOUS_ID))
        else $error("output active while distributor disabled");

    assert_cpu_off_R8: assert property (@(posedge clk) disable iff (rst)
        !cpu_en |=> (!irq_q && id_q == SPURIOUS_ID))
        else $error("output active while CPU interface disabled");

    assert_irq_has_id_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> id_q != SPURIOUS_ID)
        else $error("request raised with spurious ID");

    assert_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (id_q != SPURIOUS_ID) |-> ($past(best.prio) < {1'b0, $past(mask)}))
        else $error("reported ID not below priority mask");

    assert_running_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(best.prio) < $past(run_prio)))
        else $error("request raised without beating running priority");

endmodule

// File: rtl/hpend_select.sv
module hpend_select
    import hpsel_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         dist_en_i,
    input  logic [NUM_CPU-1:0]           cpu_en_i,
    input  logic [NUM_CPU*NUM_SRC-1:0]   src_en_i,
    input  logic [NUM_CPU*NUM_SRC-1:0]   src_pend_i,
    input  logic [NUM_SRC*PRIO_W-1:0]    src_prio_i,
    input  logic [NUM_CPU*PRIO_W-1:0]    prio_mask_i,
    input  logic [NUM_CPU*RPRIO_W-1:0]   run_prio_i,
    output logic [NUM_CPU*ID_W-1:0]      hp_id_o,
    output logic [NUM_CPU-1:0]           irq_o
);
    if (NUM_SRC < 32 || NUM_SRC % 32 != 0 || NUM_SRC > 992) begin : g_bad_src
        $error("NUM_SRC must be a multiple of 32 between 32 and 992");
    end
    if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
        $error("NUM_CPU must lie between 1 and 8");
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        cand_t best;

        hpsel_tree #(.NUM_SRC(NUM_SRC)) u_tree (
            .src_en   (src_en_i[c*NUM_SRC +: NUM_SRC]),
            .src_pend (src_pend_i[c*NUM_SRC +: NUM_SRC]),
            .src_prio (src_prio_i),
            .best     (best)
        );

        hpsel_gate u_gate (
            .clk      (clk),
            .rst      (rst),
            .best     (best),
            .dist_en  (dist_en_i),
            .cpu_en   (cpu_en_i[c]),
            .mask     (prio_mask_i[c*PRIO_W +: PRIO_W]),
            .run_prio (run_prio_i[c*RPRIO_W +: RPRIO_W]),
            .id_q     (hp_id_o[c*ID_W +: ID_W]),
            .irq_q    (irq_o[c])
        );
    end

endmodule

// File: tb/sim_hpend_select.sv
`timescale 1ns/1ps
module sim_hpend_select;
    localparam int NC = 2;
    localparam int NS = 96;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dist_en = 1'b0;
    logic [NC-1:0]    cpu_en = '0;
    logic [NC*NS-1:0] en = '0, pend = '0;
    logic [NS*8-1:0]  prio = '0;
    logic [NC*8-1:0]  mask = '0;
    logic [NC*9-1:0]  run = '0;
    logic [NC*10-1:0] hp_id;
    logic [NC-1:0]    irq;

    // copies of the inputs applied one cycle earlier
    logic r_dist;
    logic [NC-1:0]    r_cpu;
    logic [NC*NS-1:0] r_en, r_pend;
    logic [NS*8-1:0]  r_prio;
    logic [NC*8-1:0]  r_mask;
    logic [NC*9-1:0]  r_run;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hpend_select #(.NUM_CPU(NC), .NUM_SRC(NS)) u0 (
        .clk(clk), .rst(rst), .dist_en_i(dist_en), .cpu_en_i(cpu_en),
        .src_en_i(en), .src_pend_i(pend), .src_prio_i(prio),
        .prio_mask_i(mask), .run_prio_i(run), .hp_id_o(hp_id), .irq_o(irq)
    );

    task automatic check_cpu(string tag, int c, int exp_id, bit exp_irq);
        int got_id;
        got_id = int'(hp_id[c*10 +: 10]);
        checks++;
        if (got_id != exp_id || irq[c] != exp_irq) begin
            errors++;
            $display("FAIL %s cpu%0d id %0d expected %0d, irq %0b expected %0b",
                     tag, c, got_id, exp_id, irq[c], exp_irq);
        end
    endtask

    task automatic check_model(string tag);
        for (int c = 0; c < NC; c++) begin
            int best = 256;
            int bid = 1023;
            int eid = 1023;
            bit eirq = 1'b0;
            if (r_dist && r_cpu[c]) begin
                for (int s = 0; s < NS; s++) begin
                    if (r_en[c*NS+s] && r_pend[c*NS+s] && int'(r_prio[s*8 +: 8]) < best) begin
                        best = int'(r_prio[s*8 +: 8]);
                        bid = s;
                    end
                end
                if (best < int'(r_mask[c*8 +: 8])) begin
                    eid = bid;
                    eirq = best < int'(r_run[c*9 +: 9]);
                end
            end
            check_cpu(tag, c, eid, eirq);
        end
    endtask

    // inputs are set at a falling edge; the result is due at the next falling edge (R9)
    task automatic apply(string tag);
        r_dist = dist_en; r_cpu = cpu_en; r_en = en; r_pend = pend;
        r_prio = prio; r_mask = mask; r_run = run;
        @(negedge clk);
        check_model(tag);
    endtask

    task automatic set_src(int c, int s, int p);
        en[c*NS+s] = 1'b1;
        pend[c*NS+s] = 1'b1;
        prio[s*8 +: 8] = 8'(p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        en = '1; pend = '1; dist_en = 1'b1; cpu_en = '1; mask = '1; run = {NC{9'h100}};
        repeat (3) @(negedge clk);
        for (int c = 0; c < NC; c++) check_cpu("R10 reset", c, 1023, 1'b0);
        en = '0; pend = '0;
        prio = '1;
        rst = 1'b0;

        apply("R4 nothing pending");

        pend[0*NS+5] = 1'b1; en[0*NS+7] = 1'b1; prio[5*8 +: 8] = 8'h01; prio[7*8 +: 8] = 8'h01;
        apply("R1 half-qualified sources");

        en = '0; pend = '0;
        set_src(0, 10, 8'h40); set_src(0, 70, 8'h20);
        apply("R2 lower value wins");

        set_src(0, 12, 8'h20); set_src(0, 95, 8'h20);
        apply("R3 tie keeps lowest ID");

        mask[0 +: 8] = 8'h20;
        apply("R5 mask equal to winner");
        mask[0 +: 8] = 8'h21;
        apply("R5 mask one above winner");

        run[0 +: 9] = 9'h020;
        apply("R6 running equal to winner");
        run[0 +: 9] = 9'h021;
        apply("R6 running one above winner");

        set_src(1, 90, 8'h05);
        run[9 +: 9] = 9'h100;
        dist_en = 1'b0;
        apply("R7 global disable");
        dist_en = 1'b1;
        cpu_en = 2'b10;
        apply("R8 R11 CPU0 off, CPU1 on");
        cpu_en = 2'b11;
        apply("R11 both CPUs independent");

        for (int n = 0; n < 400; n++) begin
            for (int c = 0; c < NC; c++) begin
                for (int s = 0; s < NS; s++) begin
                    en[c*NS+s] = ($urandom % 4) != 0;
                    pend[c*NS+s] = ($urandom % 8) == 0;
                end
                mask[c*8 +: 8] = ($urandom % 3 == 0) ? 8'hff : 8'($urandom);
                run[c*9 +: 9] = ($urandom % 3 == 0) ? 9'h100 : 9'($urandom % 257);
                cpu_en[c] = ($urandom % 10) != 0;
            end
            for (int s = 0; s < NS; s++)
                prio[s*8 +: 8] = (n % 2 == 0) ? 8'(($urandom % 4) * 16) : 8'($urandom);
            dist_en = ($urandom % 16) != 0;
            apply("R9 random R2 R3 R5 R6");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule